// File: doc/BRIEF.md
# Serial Memory Write-Protect Controller

This block holds the protection state of a small serial memory (a 4096-byte array) and decides, request by request, whether a write may proceed. It keeps a compact status byte made of a two-bit range code, a lock-enable bit and a volatile write-enable latch. It also watches an external active-low protect pin.

Three mechanisms combine to gate writes:
- a range code that shields the top quarter, the top half or all of the array;
- a hardware lock on the status byte, armed by the lock-enable bit and the pin held low;
- the write-enable latch, which must be set before any write and clears itself after each write attempt.

A command decoder in front of the block issues single-cycle requests. The block answers each one, one cycle later, with exactly one grant or deny pulse. The command decoder, the nonvolatile programming delay and the storage array sit outside this block. The power-up value of the protection bits comes from parameters, which stand in for nonvolatile storage.

Top module: `sm_protect_ctrl`

## Requirements
- R1: After synchronous reset, the write-enable latch is 0. The range code and lock-enable bit take the parameter values INIT_RNG and INIT_LOCK_EN, and all four grant and deny outputs are 0. With the defaults, status_o reads 0x00.
- R2: A pulse on set_wel_i sets the latch, seen on status_o bit 1 one cycle later. A pulse on clr_wel_i clears it. If both pulse in the same cycle, the clear wins.
- R3: The range code sits at status bits 3:2. It maps as follows:
  - 00 shields nothing.
  - 01 shields addresses 0xC00–0xFFF.
  - 10 shields addresses 0x800–0xFFF.
  - 11 shields 0x000–0xFFF.
  An array write to a shielded address is denied even with the latch set.
- R4: An array write to an unshielded address is granted only while the latch is 1. Otherwise it is denied.
- R5: The hardware lock is active only while the lock-enable bit (status bit 7) is 1 and prot_pin_n_i is 0. While it is active, every status write is denied. The lock-enable bit therefore cannot be cleared while the pin stays low.
- R6: A status write with the latch at 1 and the lock inactive is granted. It loads the range code from sr_data_i[3:2] and lock-enable from sr_data_i[7]. The other data bits have no effect.
- R7: With the latch at 0, status writes and array writes are denied whatever the lock-enable bit and the pin are.
- R8: Any status or array write request clears the latch on the following edge, whether it was granted or denied. This takes priority over set_wel_i in the same cycle.
- R9: Each request produces exactly one grant or deny pulse, one cycle after the request. No pulse appears without a request. Status and array requests are judged independently from the same pre-edge state.
- R10: Status bits 0, 4, 5 and 6 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| set_wel_i | input | 1 | Write-enable command pulse |
| clr_wel_i | input | 1 | Write-disable command pulse |
| sr_wr_i | input | 1 | Status write request pulse |
| sr_data_i | input | 8 | New status byte for a status write |
| mem_wr_i | input | 1 | Array write request pulse |
| mem_addr_i | input | 12 | Byte address of the array write |
| prot_pin_n_i | input | 1 | External protect pin, active low |
| status_o | output | 8 | Status byte readback |
| sr_grant_o | output | 1 | Status write granted pulse |
| sr_deny_o | output | 1 | Status write denied pulse |
| mem_grant_o | output | 1 | Array write granted pulse |
| mem_deny_o | output | 1 | Array write denied pulse |

## Verification
Every result of this block is due one clock edge after its stimulus:
- the grant and deny pulses follow the edge that samples the request;
- the new status byte and the cleared latch appear at the same edge;
- a latch command shows on status_o after one edge.

The directed tasks therefore drive inputs on a falling edge and remove them on the next falling edge. They compare the outputs at that moment, when exactly one rising edge has passed. A second sample one cycle later confirms that the pulses have dropped and that the status byte holds.

// File: rtl/sm_prot_pkg.sv
package sm_prot_pkg;

    localparam int STATUS_W  = 8;
    localparam int BIT_WEL   = 1;
    localparam int BIT_RNG_L = 2;
    localparam int BIT_RNG_H = 3;
    localparam int BIT_LOCK  = 7;

    typedef enum logic [1:0] {
        RNG_NONE = 2'b00,
        RNG_QTR  = 2'b01,
        RNG_HALF = 2'b10,
        RNG_ALL  = 2'b11
    } rng_code_e;

    typedef struct packed {
        logic      lock_en;
        rng_code_e rng;
        logic      wel;
    } prot_state_t;

    typedef struct packed {
        logic grant;
        logic deny;
    } verdict_t;

    function automatic logic [STATUS_W-1:0] pack_status(prot_state_t s);
        logic [STATUS_W-1:0] v;
        v                       = '0;
        v[BIT_WEL]              = s.wel;
        v[BIT_RNG_H:BIT_RNG_L]  = s.rng;
        v[BIT_LOCK]             = s.lock_en;
        return v;
    endfunction

    function automatic verdict_t judge(logic req, logic ok);
        verdict_t v;
        v.grant = req & ok;
        v.deny  = req & ~ok;
        return v;
    endfunction

endpackage

// File: rtl/sm_wel_latch.sv
module sm_wel_latch (
    input  logic clk,
    input  logic rst,
    input  logic set_i,
    input  logic clr_i,
    input  logic wr_seen_i,
    output logic wel_o
);
    logic wel_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            wel_q <= 1'b0;
        end else if (clr_i || wr_seen_i) begin
            wel_q <= 1'b0;
        end else if (set_i) begin
            wel_q <= 1'b1;
        end
    end

    assign wel_o = wel_q;

    // R8
    wel_drop_after_wr_chk: assert property (@(posedge clk) disable iff (rst)
        wr_seen_i |=> !wel_o);

    // R2
    wel_set_chk: assert property (@(posedge clk) disable iff (rst)
        (set_i && !clr_i && !wr_seen_i) |=> wel_o);

endmodule

// File: rtl/sm_range_dec.sv
module sm_range_dec
    import sm_prot_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  rng_code_e         rng_i,
    input  logic [ADDR_W-1:0] addr_i,
    output logic              shielded_o
);
    localparam int TOP = ADDR_W - 1;

    logic top_half, top_qtr;

    assign top_half = addr_i[TOP];
    assign top_qtr  = addr_i[TOP] & addr_i[TOP-1];

    always_comb begin
        unique case (rng_i)
            RNG_NONE: shielded_o = 1'b0;
            RNG_QTR:  shielded_o = top_qtr;
            RNG_HALF: shielded_o = top_half;
            RNG_ALL:  shielded_o = 1'b1;
            default:  shielded_o = 1'b1;
        endcase
    end

    // R3
    range_nest_chk: assert final (!(rng_i == RNG_QTR && shielded_o) || addr_i[TOP]);

endmodule

// File: rtl/sm_status_reg.sv
module sm_status_reg
    import sm_prot_pkg::*;
#(
    parameter logic [1:0] INIT_RNG     = 2'b00,
    parameter logic       INIT_LOCK_EN = 1'b0
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                we_i,
    input  logic [STATUS_W-1:0] data_i,
    output rng_code_e           rng_o,
    output logic                lock_en_o
);
    rng_code_e rng_q;
    logic      lock_en_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            rng_q     <= rng_code_e'(INIT_RNG);
            lock_en_q <= INIT_LOCK_EN;
        end else if (we_i) begin
            rng_q     <= rng_code_e'(data_i[BIT_RNG_H:BIT_RNG_L]);
            lock_en_q <= data_i[BIT_LOCK];
        end
    end

    assign rng_o     = rng_q;
    assign lock_en_o = lock_en_q;

    // R5
    status_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !we_i |=> ($stable(rng_o) && $stable(lock_en_o)));

endmodule

// File: rtl/sm_protect_ctrl.sv
module sm_protect_ctrl
    import sm_prot_pkg::*;
#(
    parameter int         ADDR_W       = 12,
    parameter logic [1:0] INIT_RNG     = 2'b00,
    parameter logic       INIT_LOCK_EN = 1'b0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              set_wel_i,
    input  logic              clr_wel_i,
    input  logic              sr_wr_i,
    input  logic [7:0]        sr_data_i,
    input  logic              mem_wr_i,
    input  logic [ADDR_W-1:0] mem_addr_i,
    input  logic              prot_pin_n_i,
    output logic [7:0]        status_o,
    output logic              sr_grant_o,
    output logic              sr_deny_o,
    output logic              mem_grant_o,
    output logic              mem_deny_o
);
    prot_state_t st;
    rng_code_e   rng;
    logic        lock_en, wel, hw_lock, shielded;
    logic        sr_ok, mem_ok, sr_we;
    verdict_t    sr_v, mem_v, sr_q, mem_q;

    sm_wel_latch u_wel (
        .clk       (clk),
        .rst       (rst),
        .set_i     (set_wel_i),
        .clr_i     (clr_wel_i),
        .wr_seen_i (sr_wr_i | mem_wr_i),
        .wel_o     (wel)
    );

    sm_status_reg #(
        .INIT_RNG     (INIT_RNG),
        .INIT_LOCK_EN (INIT_LOCK_EN)
    ) u_sr (
        .clk       (clk),
        .rst       (rst),
        .we_i      (sr_we),
        .data_i    (sr_data_i),
        .rng_o     (rng),
        .lock_en_o (lock_en)
    );

    sm_range_dec #(
        .ADDR_W (ADDR_W)
    ) u_dec (
        .rng_i      (rng),
        .addr_i     (mem_addr_i),
        .shielded_o (shielded)
    );

    assign hw_lock = lock_en & ~prot_pin_n_i;
    assign sr_ok   = wel & ~hw_lock;
    assign mem_ok  = wel & ~shielded;
    assign sr_v    = judge(sr_wr_i, sr_ok);
    assign mem_v   = judge(mem_wr_i, mem_ok);
    assign sr_we   = sr_v.grant;

    always_ff @(posedge clk) begin
        if (rst) begin
            sr_q  <= '0;
            mem_q <= '0;
        end else begin
            sr_q  <= sr_v;
            mem_q <= mem_v;
        end
    end

    always_comb begin
        st.wel     = wel;
        st.rng     = rng;
        st.lock_en = lock_en;
    end

    assign status_o    = pack_status(st);
    assign sr_grant_o  = sr_q.grant;
    assign sr_deny_o   = sr_q.deny;
    assign mem_grant_o = mem_q.grant;
    assign mem_deny_o  = mem_q.deny;

    // R9
    sr_one_verdict_chk: assert property (@(posedge clk) disable iff (rst)
        sr_wr_i |=> (sr_grant_o ^ sr_deny_o));
    // R9
    mem_no_spurious_chk: assert property (@(posedge clk) disable iff (rst)
        !mem_wr_i |=> !(mem_grant_o || mem_deny_o));
    // R5
    sr_locked_deny_chk: assert property (@(posedge clk) disable iff (rst)
        (sr_wr_i && lock_en && !prot_pin_n_i) |=> sr_deny_o);
    // R3
    mem_shield_deny_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_wr_i && shielded) |=> mem_deny_o);
    // R7
    no_wel_no_grant_chk: assert property (@(posedge clk) disable iff (rst)
        !status_o[BIT_WEL] |=> !(sr_grant_o || mem_grant_o));
    // R10
    unused_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (status_o[0] | status_o[4] | status_o[5] | status_o[6]) == 1'b0);

endmodule

// File: tb/sm_protect_ctrl_tb.sv
module sm_protect_ctrl_tb_top;
    logic        clk = 1'b0;
    logic        rst;
    logic        set_wel_i, clr_wel_i, sr_wr_i, mem_wr_i, prot_pin_n_i;
    logic [7:0]  sr_data_i;
    logic [11:0] mem_addr_i;
    logic [7:0]  status_o;
    logic        sr_grant_o, sr_deny_o, mem_grant_o, mem_deny_o;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;

    sm_protect_ctrl dut_i (
        .clk(clk), .rst(rst), .set_wel_i(set_wel_i), .clr_wel_i(clr_wel_i),
        .sr_wr_i(sr_wr_i), .sr_data_i(sr_data_i), .mem_wr_i(mem_wr_i),
        .mem_addr_i(mem_addr_i), .prot_pin_n_i(prot_pin_n_i),
        .status_o(status_o), .sr_grant_o(sr_grant_o), .sr_deny_o(sr_deny_o),
        .mem_grant_o(mem_grant_o), .mem_deny_o(mem_deny_o)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    function automatic bit shield_of(logic [1:0] code, logic [11:0] a);
        case (code)
            2'b00:   return 1'b0;
            2'b01:   return a >= 12'hC00;
            2'b10:   return a >= 12'h800;
            default: return 1'b1;
        endcase
    endfunction

    task automatic idle_inputs();
        set_wel_i = 0; clr_wel_i = 0; sr_wr_i = 0; mem_wr_i = 0;
        sr_data_i = 8'h00; mem_addr_i = 12'h000;
    endtask

    task automatic cmd(bit s, bit c);
        @(negedge clk); set_wel_i = s; clr_wel_i = c;
        @(negedge clk); idle_inputs();
    endtask

    task automatic sr_write(logic [7:0] d, string req, bit exp_grant);
        @(negedge clk); sr_wr_i = 1; sr_data_i = d;
        @(negedge clk); idle_inputs();
        check(req, {sr_grant_o, sr_deny_o}, {exp_grant, !exp_grant});
        check({req, " wel cleared (R8)"}, status_o[1], 1'b0);
    endtask

    task automatic mem_write(logic [11:0] a, string req, bit exp_grant);
        @(negedge clk); mem_wr_i = 1; mem_addr_i = a;
        @(negedge clk); idle_inputs();
        check(req, {mem_grant_o, mem_deny_o}, {exp_grant, !exp_grant});
    endtask

    task automatic t_reset();
        rst = 1; idle_inputs(); prot_pin_n_i = 1;
        repeat (3) @(negedge clk);
        rst = 0;
        check("R1 status", status_o, 8'h00);
        check("R1 outputs", {sr_grant_o, sr_deny_o, mem_grant_o, mem_deny_o}, 4'b0);
    endtask

    task automatic t_latch();
        cmd(1, 0); check("R2 set", status_o, 8'h02);
        cmd(0, 1); check("R2 clear", status_o, 8'h00);
        cmd(1, 0); cmd(1, 1); check("R2 clear wins", status_o, 8'h00);
        @(negedge clk);
        check("R9 idle no pulse", {sr_grant_o, sr_deny_o, mem_grant_o, mem_deny_o}, 4'b0);
    endtask

    task automatic t_ranges();
        logic [11:0] addrs [6] = '{12'h000, 12'h7FF, 12'h800, 12'hBFF, 12'hC00, 12'hFFF};
        for (int code = 0; code < 4; code++) begin
            cmd(1, 0);
            sr_write({4'b0, code[1:0], 2'b00}, "R6 load range", 1'b1);
            check("R6 range readback", status_o, {4'b0, code[1:0], 2'b00});
            for (int i = 0; i < 6; i++) begin
                cmd(1, 0);
                mem_write(addrs[i], "R3/R4 array write", !shield_of(code[1:0], addrs[i]));
                check("R8 wel after mem", status_o[1], 1'b0);
            end
        end
        cmd(1, 0); sr_write(8'h00, "R6 restore", 1'b1);
    endtask

    task automatic t_no_latch();
        mem_write(12'h100, "R7 mem without wel", 1'b0);
        sr_write(8'h0C, "R7 sr without wel", 1'b0);
        check("R7 status unchanged", status_o, 8'h00);
        prot_pin_n_i = 0;
        sr_write(8'h0C, "R7 sr without wel pin low", 1'b0);
        prot_pin_n_i = 1;
    endtask

    task automatic t_lock();
        cmd(1, 0); sr_write(8'h80, "R6 arm lock-enable", 1'b1);
        check("R6 lock-enable readback", status_o, 8'h80);
        prot_pin_n_i = 0;
        cmd(1, 0); sr_write(8'h00, "R5 locked status write", 1'b0);
        check("R5 lock-enable kept", status_o, 8'h80);
        cmd(1, 0); mem_write(12'hFFF, "R5 lock does not gate array", 1'b1);
        prot_pin_n_i = 1;
        cmd(1, 0); sr_write(8'h00, "R5 pin high unlocks", 1'b1);
        check("R5 cleared", status_o, 8'h00);
        prot_pin_n_i = 0;
        cmd(1, 0); sr_write(8'h08, "R5 pin low but lock-enable 0", 1'b1);
        check("R5 range set", status_o, 8'h08);
        prot_pin_n_i = 1;
        cmd(1, 0); sr_write(8'h00, "R6 restore", 1'b1);
    endtask

    task automatic t_unused();
        cmd(1, 0); sr_write(8'h73, "R10 write odd bits", 1'b1);
        check("R10 unused bits zero", status_o, 8'h00);
        cmd(1, 0); sr_write(8'hFF, "R10 write all ones", 1'b1);
        check("R10 readback", status_o, 8'h8C);
        cmd(1, 0); sr_write(8'h00, "R10 restore", 1'b1);
    endtask

    task automatic t_same_cycle();
        @(negedge clk); set_wel_i = 1;
        @(negedge clk); set_wel_i = 1; sr_wr_i = 1; mem_wr_i = 1;
        sr_data_i = 8'h04; mem_addr_i = 12'hC00;
        @(negedge clk); idle_inputs();
        check("R9 sr verdict", {sr_grant_o, sr_deny_o}, 2'b10);
        check("R9 mem verdict pre-edge state", {mem_grant_o, mem_deny_o}, 2'b10);
        check("R8 request beats set", status_o, 8'h04);
        @(negedge clk);
        check("R9 pulses drop", {sr_grant_o, sr_deny_o, mem_grant_o, mem_deny_o}, 4'b0);
        cmd(1, 0); sr_write(8'h00, "R6 restore", 1'b1);
    endtask

    initial begin
        t_reset();
        t_latch();
        t_ranges();
        t_no_latch();
        t_lock();
        t_unused();
        t_same_cycle();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule